// File: doc/BRIEF.md
# Deserializing Serial Link Engine

This block sends one fixed-width word at a time over a serial link with one output line and one input line, and turns the word that comes back into a parallel word. Each transmitted bit has its own source. A select mask picks, bit by bit, either an external parallel input pin or a bit of a software-loaded data register. The word is sent most significant bit first, followed by one parity bit. The frame is therefore `W+1` bit times long. The returning frame goes to a parallel output that also serves as the readable received-data register.

Shifting advances only on cycles where the external `bit_tick` strobe is high, so the bit-clock generator stays outside the block. Frames start in one of two trigger modes. In continuous mode, frames run back to back with no idle bit time between them. In change-triggered mode, a frame is sent only when the selected source word differs from the last word sent.

The block keeps three sticky status flags: frame done, received-pattern match and parity error. Each flag is cleared by writing 1 to it, and each has its own enable onto one interrupt line. The received word is presented with a one-cycle `rx_valid` strobe and carries no ready signal. The serial link cannot stall, so the consumer must take the word in the cycle it is offered or read `rx_data`, which holds until the next frame ends.

Top module: `dsi_engine`

## Requirements
- R1: The transmitted word takes bit i from `pin_in[i]` when `cfg_src_sel[i]` is 1, and from `cfg_tx_reg[i]` when it is 0.
- R2: A frame puts the word on `sdo` most significant bit first, then one parity bit. With `cfg_odd_par`=0 the parity bit makes the count of ones among the W+1 bits even; with 1 it makes it odd. The first bit appears after the bit tick that starts the frame.
- R3: At the bit tick that samples the last bit of a frame, `rx_data` takes the W received data bits (the first received bit as MSB), and `rx_valid` is high for exactly the following cycle.
- R4: `flags[0]` (frame done) becomes 1 one cycle after `rx_valid`.
- R5: `flags[1]` (match) is set at the end of a frame when `(rx_data ^ cfg_pattern) & cfg_cmp_mask` is zero. Bits with a 0 in the mask always count as matching.
- R6: `flags[2]` (parity error) is set at the end of a frame when the received parity bit disagrees with the parity of the received data under `cfg_odd_par`.
- R7: With `cfg_trig`=0 (continuous), `cfg_enable`=1 and `bit_tick` held high, successive `rx_valid` pulses are exactly W+1 cycles apart.
- R8: With `cfg_trig`=1 (change-triggered), no frame starts while the selected word equals the last word sent. After a change, the frame starts at the next bit tick, and `rx_valid` follows W+2 ticks after the change is applied.
- R9: Flags are sticky. A 1 on `flag_clr[i]` clears `flags[i]` at the next edge and leaves the other flags alone. If a set and a clear of the same flag land in one cycle, the set wins.
- R10: `irq` is high exactly when some flag is 1 and its `irq_en` bit is 1.
- R11: After reset, `sdo`, `rx_valid`, `rx_data`, `flags` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Allows new frames to start |
| cfg_trig | input | 1 | 0 continuous, 1 change-triggered |
| cfg_odd_par | input | 1 | 0 even parity, 1 odd parity |
| cfg_src_sel | input | W | Per-bit source: 1 pin, 0 register |
| cfg_tx_reg | input | W | Software data register |
| pin_in | input | W | Parallel input pins |
| cfg_pattern | input | W | Match pattern |
| cfg_cmp_mask | input | W | Bits taking part in the match |
| irq_en | input | 3 | Per-flag interrupt enable |
| flag_clr | input | 3 | Write-1-to-clear strobes |
| bit_tick | input | 1 | Bit-time strobe |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| rx_data | output | W | Received word (parallel pins and register view) |
| rx_valid | output | 1 | One-cycle strobe for a new received word |
| flags | output | 3 | {parity error, match, done} |
| irq | output | 1 | Interrupt |

## Verification
A frame end can set the done flag in the same cycle that software writes 1 to clear it. The bench holds `flag_clr[0]` high across a continuous-mode frame and samples `flags[0]` in the cycle after `rx_valid`, where it must read 1 because the set wins. One cycle later, with the clear still held and no new frame ending, it must read 0. In the same way, a frame reload lands on the bit tick that samples the previous frame's parity bit. The bench judges this by the exact W+1-cycle spacing of `rx_valid` pulses.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int FLAG_DONE  = 0;
  localparam int FLAG_MATCH = 1;
  localparam int FLAG_PERR  = 2;
  localparam int NFLAGS     = 3;

  typedef enum logic {
    TRIG_CONT   = 1'b0,
    TRIG_CHANGE = 1'b1
  } trig_e;
endpackage

// File: rtl/dsi_tx_select.sv
module dsi_tx_select #(
  parameter int W = 16
) (
  input  logic [W-1:0] src_sel,
  input  logic [W-1:0] pin_val,
  input  logic [W-1:0] reg_val,
  input  logic         odd_par,
  input  logic [W-1:0] last_word,
  output logic [W-1:0] word,
  output logic         par_bit,
  output logic         differs
);
  // per-bit source multiplexer
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign word[i] = src_sel[i] ? pin_val[i] : reg_val[i];
  end

  assign par_bit = (^word) ^ odd_par;
  assign differs = (word != last_word);
endmodule

// File: rtl/dsi_shifter.sv
module dsi_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         go,
  input  logic [W-1:0] load_word,
  input  logic         load_par,
  input  logic         sdi,
  output logic         sdo,
  output logic         load_fire,
  output logic         frame_done,
  output logic [W:0]   frame_q
);
  localparam int FL = W + 1;
  localparam int CW = $clog2(FL);

  logic [W:0]    tx_sh;
  logic [W-1:0]  rx_sh;
  logic [CW-1:0] cnt;
  logic          busy;
  logic          last_bit;

  assign last_bit  = busy && (cnt == CW'(W));
  assign load_fire = bit_tick && go && (!busy || last_bit);
  assign sdo       = tx_sh[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (bit_tick) begin
      if (busy) begin
        rx_sh <= {rx_sh[W-2:0], sdi};
        tx_sh <= {tx_sh[W-1:0], 1'b0};
        cnt   <= cnt + 1'b1;
        if (last_bit) busy <= 1'b0;
      end
      if (load_fire) begin
        tx_sh <= {load_word, load_par};
        cnt   <= '0;
        busy  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      frame_q    <= '0;
    end else begin
      frame_done <= bit_tick && last_bit;
      if (bit_tick && last_bit) frame_q <= {rx_sh, sdi};
    end
  end
endmodule

// File: rtl/dsi_rx_check.sv
module dsi_rx_check #(
  parameter int W = 16
) (
  input  logic [W:0]   frame,
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] cmp_mask,
  input  logic         odd_par,
  output logic [W-1:0] data,
  output logic         match,
  output logic         par_err
);
  assign data    = frame[W:1];
  assign match   = ((data ^ pattern) & cmp_mask) == '0;
  assign par_err = frame[0] != ((^data) ^ odd_par);
endmodule

// File: rtl/dsi_flags.sv
module dsi_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] en_vec,
  output logic [N-1:0] flag_q,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (clr_vec[i]) flag_q[i] <= 1'b0;
    end
  end

  assign irq = |(flag_q & en_vec);
endmodule

// File: rtl/dsi_engine.sv
module dsi_engine
  import dsi_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_trig,
  input  logic              cfg_odd_par,
  input  logic [W-1:0]      cfg_src_sel,
  input  logic [W-1:0]      cfg_tx_reg,
  input  logic [W-1:0]      pin_in,
  input  logic [W-1:0]      cfg_pattern,
  input  logic [W-1:0]      cfg_cmp_mask,
  input  logic [NFLAGS-1:0] irq_en,
  input  logic [NFLAGS-1:0] flag_clr,
  input  logic              bit_tick,
  input  logic              sdi,
  output logic              sdo,
  output logic [W-1:0]      rx_data,
  output logic              rx_valid,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  trig_e         trig;
  logic [W-1:0]  tx_word;
  logic [W-1:0]  last_tx;
  logic          tx_par;
  logic          differs;
  logic          pending;
  logic          go;
  logic          load_fire;
  logic          frame_done;
  logic [W:0]    frame_q;
  logic          rx_match;
  logic          rx_perr;
  logic [NFLAGS-1:0] set_vec;

  assign trig = trig_e'(cfg_trig);

  dsi_tx_select #(.W(W)) u_sel (
    .src_sel   (cfg_src_sel),
    .pin_val   (pin_in),
    .reg_val   (cfg_tx_reg),
    .odd_par   (cfg_odd_par),
    .last_word (last_tx),
    .word      (tx_word),
    .par_bit   (tx_par),
    .differs   (differs)
  );

  assign go = cfg_enable && ((trig == TRIG_CONT) || pending || differs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tx <= '0;
      pending <= 1'b0;
    end else begin
      if (load_fire) last_tx <= tx_word;
      if (load_fire || trig == TRIG_CONT) pending <= 1'b0;
      else if (differs)                   pending <= 1'b1;
    end
  end

  dsi_shifter #(.W(W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .go         (go),
    .load_word  (tx_word),
    .load_par   (tx_par),
    .sdi        (sdi),
    .sdo        (sdo),
    .load_fire  (load_fire),
    .frame_done (frame_done),
    .frame_q    (frame_q)
  );

  dsi_rx_check #(.W(W)) u_chk_rx (
    .frame    (frame_q),
    .pattern  (cfg_pattern),
    .cmp_mask (cfg_cmp_mask),
    .odd_par  (cfg_odd_par),
    .data     (rx_data),
    .match    (rx_match),
    .par_err  (rx_perr)
  );

  assign rx_valid = frame_done;

  always_comb begin
    set_vec             = '0;
    set_vec[FLAG_DONE]  = frame_done;
    set_vec[FLAG_MATCH] = frame_done && rx_match;
    set_vec[FLAG_PERR]  = frame_done && rx_perr;
  end

  dsi_flags #(.N(NFLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (flag_clr),
    .en_vec  (irq_en),
    .flag_q  (flags),
    .irq     (irq)
  );
endmodule

// File: rtl/dsi_engine_chk.sv
module dsi_engine_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_valid,
  input logic [2:0]   flags,
  input logic [2:0]   flag_clr,
  input logic [2:0]   irq_en,
  input logic         irq
);
  // R3: the received-word strobe lasts one cycle
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4: frame done follows the strobe
  p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> flags[0]);

  // R10: no enabled flag, no interrupt
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & irq_en) == 3'b000) |-> !irq);

  // R9: a flag only falls after a clear strobe
  for (genvar i = 0; i < 3; i++) begin : g_sticky
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(flag_clr[i]));
  end
endmodule

bind dsi_engine dsi_engine_chk #(.W(W)) u_engine_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .flags    (flags),
  .flag_clr (flag_clr),
  .irq_en   (irq_en),
  .irq      (irq)
);

// File: tb/dsi_engine_tb_top.sv
module dsi_engine_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_trig = 1'b0, cfg_odd_par = 1'b0;
  logic [W-1:0] cfg_src_sel = '0, cfg_tx_reg = '0, pin_in = '0;
  logic [W-1:0] cfg_pattern = '0, cfg_cmp_mask = '0;
  logic [2:0] irq_en = '0, flag_clr = '0;
  logic bit_tick = 1'b1;
  logic inv = 1'b0;
  logic sdi, sdo, rx_valid, irq;
  logic [W-1:0] rx_data;
  logic [2:0] flags;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign sdi = sdo ^ inv;

  dsi_engine #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_trig(cfg_trig),
    .cfg_odd_par(cfg_odd_par), .cfg_src_sel(cfg_src_sel), .cfg_tx_reg(cfg_tx_reg),
    .pin_in(pin_in), .cfg_pattern(cfg_pattern), .cfg_cmp_mask(cfg_cmp_mask),
    .irq_en(irq_en), .flag_clr(flag_clr), .bit_tick(bit_tick), .sdi(sdi),
    .sdo(sdo), .rx_data(rx_data), .rx_valid(rx_valid), .flags(flags), .irq(irq)
  );

  typedef struct packed {
    logic [W-1:0] sel, pin, rg, pat, msk;
    logic odd, inv;
    logic [W-1:0] exp;
    logic em, ep;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{16'hFFFF, 16'hA5C3, 16'h0000, 16'hA5C3, 16'hFFFF, 1'b0, 1'b0, 16'hA5C3, 1'b1, 1'b0},
    '{16'h0000, 16'hFFFF, 16'h1234, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h1234, 1'b1, 1'b0},
    '{16'hFF00, 16'hABCD, 16'h1234, 16'hAC00, 16'hFF00, 1'b0, 1'b0, 16'hAB34, 1'b0, 1'b0},
    '{16'h00FF, 16'h00F0, 16'h5500, 16'hAA0F, 16'hFFFF, 1'b0, 1'b1, 16'hAA0F, 1'b1, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // waits at negedges for rx_valid; returns the number of edges waited
  task automatic wait_valid(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rx_valid && n < 200);
  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int n;
    logic [W:0] cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(sdo == 1'b0, "R11 sdo", 32'(sdo), 0);
    chk(rx_valid == 1'b0, "R11 rx_valid", 32'(rx_valid), 0);
    chk(rx_data == '0, "R11 rx_data", 32'(rx_data), 0);
    chk(flags == '0, "R11 flags", 32'(flags), 0);
    chk(irq == 1'b0, "R11 irq", 32'(irq), 0);

    // table walk: R1 source select, R3 data, R4 done, R5 match, R6 parity
    foreach (VECS[i]) begin
      cfg_enable = 1'b0;
      repeat (20) @(negedge clk);
      cfg_src_sel = VECS[i].sel; pin_in = VECS[i].pin; cfg_tx_reg = VECS[i].rg;
      cfg_pattern = VECS[i].pat; cfg_cmp_mask = VECS[i].msk;
      cfg_odd_par = VECS[i].odd; inv = VECS[i].inv; cfg_trig = 1'b0;
      flag_clr = 3'b111;
      @(negedge clk);
      flag_clr = 3'b000;
      cfg_enable = 1'b1;
      wait_valid(n);
      chk(rx_data == VECS[i].exp, "R1/R3 rx_data", 32'(rx_data), 32'(VECS[i].exp));
      @(negedge clk);
      chk(flags[0] == 1'b1, "R4 done flag", 32'(flags[0]), 1);
      chk(flags[1] == VECS[i].em, "R5 match flag", 32'(flags[1]), 32'(VECS[i].em));
      chk(flags[2] == VECS[i].ep, "R6 parity flag", 32'(flags[2]), 32'(VECS[i].ep));
    end
    inv = 1'b0;

    // R7 back-to-back spacing in continuous mode
    wait_valid(n);
    wait_valid(n);
    chk(n == W + 1, "R7 frame spacing", 32'(n), W + 1);

    // R10 interrupt gating (flags currently nonzero)
    irq_en = 3'b000;
    #1;
    chk(irq == 1'b0, "R10 irq masked", 32'(irq), 0);
    irq_en = 3'b001;
    #1;
    chk(irq == 1'b1, "R10 irq enabled", 32'(irq), 1);
    irq_en = 3'b000;

    // R9 set and clear of the done flag in the same cycle: set wins
    @(negedge clk);
    flag_clr = 3'b001;
    wait_valid(n);
    @(negedge clk);
    chk(flags[0] == 1'b1, "R9 set beats clear", 32'(flags[0]), 1);
    @(negedge clk);
    chk(flags[0] == 1'b0, "R9 clear after", 32'(flags[0]), 0);
    flag_clr = 3'b000;

    // R9 clear one flag, others stay (match and perr set by vector 4)
    chk(flags[2:1] == 2'b11, "R9 sticky others", 32'(flags), 32'h6);
    flag_clr = 3'b010;
    @(negedge clk);
    flag_clr = 3'b000;
    chk(flags[2:1] == 2'b10, "R9 single clear", 32'(flags), 32'h4);

    // R8 change-triggered mode
    cfg_enable = 1'b0;
    repeat (20) @(negedge clk);
    cfg_src_sel = '0; cfg_tx_reg = 16'h3C5A; cfg_odd_par = 1'b1; cfg_trig = 1'b1;
    cfg_enable = 1'b1;
    wait_valid(n);
    chk(rx_data == 16'h3C5A, "R8 first change frame", 32'(rx_data), 32'h3C5A);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rx_valid) n++;
    end
    chk(n == 0, "R8 no frame when unchanged", 32'(n), 0);
    cfg_tx_reg = 16'h8001;
    for (int k = 0; k <= W; k++) begin
      @(negedge clk);
      cap[W - k] = sdo;
    end
    // R2: 8001 has two ones; odd parity bit is 1
    chk(cap == {16'h8001, 1'b1}, "R2 serial order and parity", 32'(cap),
        32'({16'h8001, 1'b1}));
    @(negedge clk);
    chk(rx_valid == 1'b1, "R8 latency W+2", 32'(rx_valid), 1);
    chk(rx_data == 16'h8001, "R8 changed word", 32'(rx_data), 32'h8001);
    @(negedge clk);
    chk(flags[2] == 1'b1, "R6 no new error keeps sticky", 32'(flags[2]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule